// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block sits on the target side of a bus bridge. It takes an address arriving from the PCI side and compares it with three programmable inbound memory windows. When the address falls inside one of them, the block turns it into a host-memory address. Every window maps onto host address 0, so translation removes the window's base and keeps the offset into the window. A fourth register uses the same encoding and defines an I/O-space window. A lookup with the I/O flag set is checked against that register alone.

Each window register holds two fields. Bits 31:20 carry the upper address bits of the window base. Bits 19:16 carry a size code, where the window size is 1 MB shifted left by the code. Software loads these registers through a simple word-write port that carries only bits 31:16 of the register word, since nothing below bit 16 is stored. A lookup presented with valid produces its result one clock later: a valid strobe, a hit flag, the index of the window that matched, and the translated address.

Top module: `inboundWinDec`

## Requirements
- R1: After reset, every memory window and the I/O window hold size code 0xF, so no lookup hits until software loads a register. rspValid and rspHit reset low.
- R2: A write with cfgOfs equal to 0x50, 0x54 or 0x58 loads memory window 0, 1 or 2. A write with cfgOfs equal to 0x00 loads the I/O window. A write to any other offset changes no window.
- R3: For a window with base field B (bits 31:20) and code C (bits 19:16) in the range 0x0..0xB, the size is S = 2^(20+C). An address A matches when floor(A/S) equals floor({B,20'h0}/S). Base bits below S are ignored.
- R4: A window whose size code is 0xC, 0xD, 0xE or 0xF never matches.
- R5: When more than one memory window matches, the lowest-numbered window is reported.
- R6: On a hit, rspAddr equals A mod S, because the host-side base of every window is 0.
- R7: rspValid equals reqValid of the previous cycle. When there is no hit, rspHit is 0 and rspWin and rspAddr are 0.
- R8: A lookup with reqIo=1 is compared only with the I/O window, and a hit reports rspWin=3. A lookup with reqIo=0 is compared only with the three memory windows, and a hit reports rspWin 0..2.
- R9: A write and a lookup in the same cycle return a result computed from the window contents as they were before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgOfs | input | 8 | Byte offset of the register written |
| cfgWrHi | input | 16 | Bits 31:16 of the register word (base field and size code) |
| reqValid | input | 1 | Lookup request valid |
| reqIo | input | 1 | 1: look up in the I/O window, 0: look up in the memory windows |
| reqAddr | input | 32 | PCI-side address to decode |
| rspValid | output | 1 | Lookup result valid, one cycle after reqValid |
| rspHit | output | 1 | The address fell inside a window |
| rspWin | output | 2 | Matching window index; 3 means the I/O window |
| rspAddr | output | 32 | Translated host address |

## Verification
The assertions assume only that reqValid, reqIo and reqAddr are stable around each clock edge. Because of that, they relate a response to the request one cycle earlier: the low 20 address bits pass through on a hit, the index range depends on reqIo, and a miss returns zeros. The bench drives requests away from the clock edge. Its directed and random sequences write to both the decoded offsets and offsets the block does not decode. They also present addresses just inside and just outside each window, so every window-boundary case stays inside what the checker assumes.

// File: rtl/inboundWinDecPkg.sv
package inboundWinDecPkg;
  localparam int NUM_WIN  = 3;
  localparam int ADDR_W   = 32;
  localparam int FIELD_W  = 16;              // stored bits 31:16 of a register word
  localparam int CODE_W   = 4;
  localparam int BASE_W   = FIELD_W - CODE_W;
  localparam int BASE_LSB = ADDR_W - BASE_W; // 20: 1 MB granule
  localparam int CODE_MAX = ADDR_W - 1 - BASE_LSB; // 11: 2 GB largest
  localparam int IDX_W    = $clog2(NUM_WIN + 1);
  localparam int OFS_W    = 8;
  localparam logic [FIELD_W-1:0] FIELD_RST = {{BASE_W{1'b0}}, {CODE_W{1'b1}}};

  typedef struct packed {
    logic [NUM_WIN-1:0] winLoad;
    logic               ioLoad;
    logic               capture;
  } strobeT;

  function automatic logic codeOk(input logic [CODE_W-1:0] code);
    return int'(code) <= CODE_MAX;
  endfunction

  function automatic logic [ADDR_W-1:0] offsetMask(input logic [CODE_W-1:0] code);
    logic [ADDR_W-1:0] one;
    one = {{(ADDR_W-1){1'b0}}, 1'b1};
    if (codeOk(code)) return (one << (BASE_LSB + int'(code))) - one;
    return '0;
  endfunction

  function automatic logic fieldMatch(input logic [FIELD_W-1:0] f,
                                      input logic [ADDR_W-1:0]  addr);
    logic [ADDR_W-1:0] baseFull;
    logic [ADDR_W-1:0] keep;
    baseFull = {f[FIELD_W-1:CODE_W], {BASE_LSB{1'b0}}};
    keep     = ~offsetMask(f[CODE_W-1:0]);
    return codeOk(f[CODE_W-1:0]) && ((addr & keep) == (baseFull & keep));
  endfunction
endpackage

// File: rtl/inboundWinDecCtrl.sv
module inboundWinDecCtrl
  import inboundWinDecPkg::*;
#(
  parameter int IO_OFS     = 'h00,
  parameter int WIN_OFS0   = 'h50,
  parameter int WIN_STRIDE = 4
) (
  input  logic             cfgWrEn,
  input  logic [OFS_W-1:0] cfgOfs,
  input  logic             reqValid,
  output strobeT           strobe
);
  for (genvar k = 0; k < NUM_WIN; k++) begin : g_winDec
    localparam logic [OFS_W-1:0] MY_OFS = OFS_W'(WIN_OFS0 + k * WIN_STRIDE);
    assign strobe.winLoad[k] = cfgWrEn && (cfgOfs == MY_OFS);
  end

  assign strobe.ioLoad  = cfgWrEn && (cfgOfs == OFS_W'(IO_OFS));
  assign strobe.capture = reqValid;
endmodule

// File: rtl/inboundWinDecPath.sv
module inboundWinDecPath
  import inboundWinDecPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic [FIELD_W-1:0] cfgWrHi,
  input  logic               reqIo,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               rspValid,
  output logic               rspHit,
  output logic [IDX_W-1:0]   rspWin,
  output logic [ADDR_W-1:0]  rspAddr
);
  localparam logic [IDX_W-1:0] IO_IDX = IDX_W'(NUM_WIN);

  logic [FIELD_W-1:0] winReg [NUM_WIN];
  logic [FIELD_W-1:0] ioReg;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_winReg
    always_ff @(posedge clk) begin
      if (!rstN)                  winReg[k] <= FIELD_RST;
      else if (strobe.winLoad[k]) winReg[k] <= cfgWrHi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             ioReg <= FIELD_RST;
    else if (strobe.ioLoad) ioReg <= cfgWrHi;
  end

  logic [NUM_WIN-1:0] memHit;
  logic               ioHit;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_cmp
    assign memHit[k] = !reqIo && fieldMatch(winReg[k], reqAddr);
  end
  assign ioHit = reqIo && fieldMatch(ioReg, reqAddr);

  logic               anyHit;
  logic [IDX_W-1:0]   selIdx;
  logic [FIELD_W-1:0] selField;

  always_comb begin
    selIdx   = '0;
    selField = ioReg;
    for (int k = NUM_WIN - 1; k >= 0; k--) begin
      if (memHit[k]) begin
        selIdx   = IDX_W'(k);
        selField = winReg[k];
      end
    end
    if (ioHit) begin
      selIdx   = IO_IDX;
      selField = ioReg;
    end
    anyHit = ioHit || (|memHit);
  end

  logic               takeHit;
  assign takeHit = strobe.capture && anyHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspWin   <= '0;
      rspAddr  <= '0;
    end else begin
      rspValid <= strobe.capture;
      rspHit   <= takeHit;
      rspWin   <= takeHit ? selIdx : '0;
      rspAddr  <= takeHit ? (reqAddr & offsetMask(selField[CODE_W-1:0])) : '0;
    end
  end
endmodule

// File: rtl/inboundWinDec.sv
module inboundWinDec
  import inboundWinDecPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic [7:0]   cfgOfs,
  input  logic [15:0]  cfgWrHi,
  input  logic         reqValid,
  input  logic         reqIo,
  input  logic [31:0]  reqAddr,
  output logic         rspValid,
  output logic         rspHit,
  output logic [1:0]   rspWin,
  output logic [31:0]  rspAddr
);
  strobeT strobe;

  inboundWinDecCtrl u_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgOfs  (cfgOfs),
    .reqValid(reqValid),
    .strobe  (strobe)
  );

  inboundWinDecPath u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgWrHi (cfgWrHi),
    .reqIo   (reqIo),
    .reqAddr (reqAddr),
    .rspValid(rspValid),
    .rspHit  (rspHit),
    .rspWin  (rspWin),
    .rspAddr (rspAddr)
  );
endmodule

// File: rtl/inboundWinDecChk.sv
module inboundWinDecChk
  import inboundWinDecPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqIo,
  input logic [BASE_LSB-1:0] reqAddrLow,
  input logic                rspValid,
  input logic                rspHit,
  input logic [IDX_W-1:0]    rspWin,
  input logic [ADDR_W-1:0]   rspAddr
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspHit));
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (rspWin == '0 && rspAddr == '0));
  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspAddr[BASE_LSB-1:0] == $past(reqAddrLow)));
  a_r8_io_index: assert property (@(posedge clk) disable iff (!rstN)
    (rspHit && $past(reqIo)) |-> (rspWin == IDX_W'(NUM_WIN)));
  a_r8_mem_index: assert property (@(posedge clk) disable iff (!rstN)
    (rspHit && !$past(reqIo)) |-> (rspWin < IDX_W'(NUM_WIN)));
endmodule

bind inboundWinDec inboundWinDecChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqIo     (reqIo),
  .reqAddrLow(reqAddr[19:0]),
  .rspValid  (rspValid),
  .rspHit    (rspHit),
  .rspWin    (rspWin),
  .rspAddr   (rspAddr)
);

// File: tb/inboundWinDec_tb_top.sv
module inboundWinDec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgOfs = '0;
  logic [15:0] cfgWrHi = '0;
  logic        reqValid = 1'b0;
  logic        reqIo = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        rspValid, rspHit;
  logic [1:0]  rspWin;
  logic [31:0] rspAddr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] mdlWin [3];
  logic [31:0] mdlIo;

  always #(CLK_PERIOD/2) clk = ~clk;

  inboundWinDec dut_i (.*);

  function automatic bit inWin(input logic [31:0] r, input logic [31:0] a,
                               output logic [31:0] host);
    int code = int'(r[19:16]);
    longint sz, base;
    host = 0;
    if (code > 11) return 0;
    sz   = longint'(1) << (20 + code);
    base = longint'({r[31:20], 20'h0});
    if ((longint'(a) / sz) != (base / sz)) return 0;
    host = 32'(longint'(a) % sz);
    return 1;
  endfunction

  task automatic expect4(input string tag, input bit v, input bit h,
                         input int w, input logic [31:0] t);
    checks++;
    if (rspValid !== v || rspHit !== h || rspWin !== 2'(w) || rspAddr !== t) begin
      fails++;
      $display("FAIL %s: got v=%0b hit=%0b win=%0d addr=%h, expected v=%0b hit=%0b win=%0d addr=%h",
               tag, rspValid, rspHit, rspWin, rspAddr, v, h, w, t);
    end
  endtask

  task automatic step(input string tag, input bit wr, input logic [7:0] ofs,
                      input logic [31:0] data, input bit v, input bit io,
                      input logic [31:0] a);
    bit eh = 0;
    int ew = 0;
    logic [31:0] et = 0;
    logic [31:0] tmp;
    cfgWrEn = wr; cfgOfs = ofs; cfgWrHi = data[31:16];
    reqValid = v; reqIo = io; reqAddr = a;
    if (v) begin
      if (io) begin
        if (inWin(mdlIo, a, tmp)) begin eh = 1; ew = 3; et = tmp; end
      end else begin
        for (int k = 2; k >= 0; k--)
          if (inWin(mdlWin[k], a, tmp)) begin eh = 1; ew = k; et = tmp; end
      end
    end
    if (wr) begin
      if (ofs == 8'h50) mdlWin[0] = data;
      if (ofs == 8'h54) mdlWin[1] = data;
      if (ofs == 8'h58) mdlWin[2] = data;
      if (ofs == 8'h00) mdlIo = data;
    end
    @(posedge clk);
    @(negedge clk);
    expect4(tag, v, eh, ew, et);
  endtask

  task automatic wr(input string tag, input logic [7:0] ofs, input logic [31:0] d);
    step(tag, 1, ofs, d, 0, 0, 0);
  endtask

  task automatic look(input string tag, input bit io, input logic [31:0] a);
    step(tag, 0, 0, 0, 1, io, a);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) mdlWin[k] = 32'h000F_0000;
    mdlIo = 32'h000F_0000;
    repeat (3) @(negedge clk);
    expect4("R1 reset outputs", 0, 0, 0, 0);
    rstN = 1'b1;
    look("R1 miss after reset", 0, 32'h0000_0000);
    look("R1 io miss after reset", 1, 32'h0000_0000);

    wr("R2 load win0", 8'h50, 32'h4004_0000);
    look("R6 win0 hit translate", 0, 32'h4012_3456);
    look("R3 win0 top edge", 0, 32'h40FF_FFFF);
    look("R3 win0 above", 0, 32'h4100_0000);
    look("R3 win0 below", 0, 32'h3FFF_FFFF);

    wr("R2 load win1", 8'h54, 32'h1238_0000);
    look("R3 low base bits ignored", 0, 32'h1FFF_FFFF);
    look("R3 low base bits ignored lo", 0, 32'h1000_0000);

    wr("R4 win2 code C", 8'h58, 32'h000C_0000);
    look("R4 code C never hits", 0, 32'h0000_0000);
    wr("R4 win2 code F", 8'h58, 32'h000F_0000);
    look("R4 code F never hits", 0, 32'h0000_1000);

    wr("R5 win2 1MB at 0", 8'h58, 32'h0000_0000);
    wr("R5 win1 2GB at 0", 8'h54, 32'h000B_0000);
    look("R5 win1 beats win2", 0, 32'h0000_0010);
    wr("R5 win0 4MB at 0", 8'h50, 32'h0002_0000);
    look("R5 win0 beats all", 0, 32'h0000_0010);
    look("R5 only win1 covers", 0, 32'h0050_0000);
    look("R3 2GB upper edge", 0, 32'h7FFF_FFFF);
    look("R3 2GB miss", 0, 32'h8000_0000);

    wr("R2 bad ofs 5C", 8'h5C, 32'h8000_0000);
    wr("R2 bad ofs 52", 8'h52, 32'h8000_0000);
    look("R2 undecoded writes ignored", 0, 32'h8000_0000);
    wr("R2 bad ofs 04", 8'h04, 32'h0000_0000);
    look("R2 io untouched", 1, 32'h0000_0000);

    wr("R8 load io", 8'h00, 32'h0001_0000);
    look("R8 io hit", 1, 32'h001F_FFFF);
    look("R8 io miss", 1, 32'h0020_0000);
    look("R8 mem ignores io", 0, 32'h0020_0000);
    look("R8 io ignores mem", 1, 32'h0000_0010);

    step("R9 same-cycle old contents", 1, 8'h50, 32'h000F_0000, 1, 0, 32'h0000_0010);
    look("R9 new contents", 0, 32'h0000_0010);

    step("R7 idle", 0, 0, 0, 0, 0, 32'h0000_0010);
    step("R7 idle io", 0, 0, 0, 0, 1, 32'h0000_0010);

    for (int n = 0; n < 400; n++) begin
      logic [7:0] ofsSet [6] = '{8'h00, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h4C};
      logic [31:0] d = $urandom;
      logic [31:0] a = $urandom;
      if (($urandom % 3) == 0) a = a & 32'h03FF_FFFF;
      step("R3 R5 R6 random", ($urandom % 4) == 0, ofsSet[$urandom % 6], d,
           ($urandom % 5) != 0, ($urandom % 4) == 0, a);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule